// File: doc/BRIEF.md
# Video Decoder Syntax Error Monitor

This block runs next to a video bitstream decoder and raises an interrupt when the decoded data breaks a limit. The decoder hands over decoded syntax values one per cycle. Each value comes with a valid strobe and a kind code. The monitor range-checks each value. The permitted range for the macroblock kind and the sub-partition kind depends on the slice type that is programmed.

The block also counts coefficients inside each block, when the coefficient check is enabled. A decode-time counter runs from a start pulse to a done pulse. It compares the elapsed cycles with a programmed limit. The counter also notes whether the input stream ran dry while a decode was still in progress.

Every error source owns one sticky flag. Software clears a flag by writing a one to its bit in the clear mask. A cause code reports the most urgent source that fired most recently. A single interrupt pulse goes out whenever a flag changes from clear to set. All three outputs are registered, so each one reacts on the clock edge that samples the offending input.

Top module: `vdec_err_mon`

## Requirements
- R1: With `syn_kind`=0 (macroblock type), the unsigned value may not exceed the slice limit: 25 when `cfg_slice_type`=0 (intra), 30 when it is 1 (predicted), 48 when it is 2 (bi-predicted). Code 3 uses the intra limit. A larger value sets flag bit 2.
- R2: Flag bit 3 is set by two cases. The first is a `syn_kind`=1 (sub-partition type) value above 2 in a predicted slice, above 11 in a bi-predicted slice, or any such value in an intra slice. The second is a `syn_kind`=2 (intra prediction mode) value above 7.
- R3: With `syn_kind`=3 (reference index), a value greater than `cfg_num_ref` minus one sets flag bit 4.
- R4: With `syn_kind`=4 (quantiser delta), the value is read as two's complement. A value outside -26..25 sets flag bit 5.
- R5: A decode starts when `dec_start` is sampled and ends when `dec_done` is sampled. If the decode has stayed open for more than `cfg_timeout` sampled cycles without `dec_done`, flag bit 0 is set. This happens once per decode. A new `dec_start` restarts the count.
- R6: When `coef_mode`=1, the 65th `coef_valid` after a `blk_start` sets flag bit 6. The flag is not raised for 64 or fewer coefficients, and it is never raised when `coef_mode`=0.
- R7: `strm_empty` sampled while a decode is open, and not in its done cycle, sets flag bit 1. Outside a decode it is ignored.
- R8: After reset, the flags, the cause code and the interrupt are zero. A flag stays set until a one is written to the same bit of `err_clr`. If a clear and a new error hit one bit in the same cycle, the bit stays set.
- R9: `err_irq` is high for exactly the cycle after an error is sampled, and only if that error's flag was clear. An error on a flag that is already set gives no pulse.
- R10: On each cycle with any error, `err_cause` loads the code of the highest-priority error of that cycle. The codes, from highest priority down, are: 1 timeout, 2 stream empty, 3 macroblock, 4 sub-partition, 5 reference, 6 delta, 7 coefficient. Otherwise it holds its value.
- R11: Syntax values are checked only when `syn_valid` is high. Kind codes 5 to 7 are never checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_slice_type | input | 2 | Slice type: 0 intra, 1 predicted, 2 bi-predicted, 3 treated as intra |
| cfg_num_ref | input | REF_W | Number of active reference pictures |
| cfg_timeout | input | TMR_W | Decode time limit in cycles |
| coef_mode | input | 1 | Enables the coefficient overflow check |
| syn_valid | input | 1 | Syntax value strobe |
| syn_kind | input | 3 | Kind of the syntax value |
| syn_value | input | VAL_W | Syntax value |
| blk_start | input | 1 | Start of a coefficient block |
| coef_valid | input | 1 | One coefficient delivered |
| dec_start | input | 1 | Decode start pulse |
| dec_done | input | 1 | Decode done pulse |
| strm_empty | input | 1 | Input stream exhausted |
| err_clr | input | 7 | Write-one-to-clear mask for the flags |
| err_flags | output | 7 | Sticky error flags |
| err_cause | output | 3 | Code of the latest highest-priority error |
| err_irq | output | 1 | One-cycle interrupt pulse |

## Verification
Errors in internal state reach the ports one edge after the input that exposes them. A range limit chosen from the wrong slice type, or a limit off by one, shows up as a flag that is missing or extra right after the single value that sits on the boundary. A coefficient or timer counter that slips by one moves the flag by one cycle. The bench catches this because it compares against its cycle model on every clock. A wrong priority or a lost sticky bit changes `err_cause`, `err_irq` or `err_flags` on the very next cycle.

// File: rtl/vdec_err_pkg.sv
package vdec_err_pkg;

  localparam int NCAUSE = 7;

  // Flag bit positions; the cause code is bit index + 1 (lower index wins)
  localparam int B_TO   = 0;
  localparam int B_VLD  = 1;
  localparam int B_MB   = 2;
  localparam int B_SUB  = 3;
  localparam int B_REF  = 4;
  localparam int B_DQ   = 5;
  localparam int B_COEF = 6;

  typedef enum logic [1:0] {
    SL_I = 2'd0,
    SL_P = 2'd1,
    SL_B = 2'd2,
    SL_X = 2'd3
  } slice_e;

  localparam logic [2:0] SK_MBT = 3'd0;
  localparam logic [2:0] SK_SUB = 3'd1;
  localparam logic [2:0] SK_IPM = 3'd2;
  localparam logic [2:0] SK_REF = 3'd3;
  localparam logic [2:0] SK_DQ  = 3'd4;

  localparam int IPM_MAX = 7;
  localparam int DQ_LO   = -26;
  localparam int DQ_HI   = 25;

  function automatic int mb_max(input logic [1:0] sl);
    case (sl)
      SL_P:    return 30;
      SL_B:    return 48;
      default: return 25;
    endcase
  endfunction

  // -1 means no value is legal (intra slices carry no sub-partitions)
  function automatic int sub_max(input logic [1:0] sl);
    case (sl)
      SL_P:    return 2;
      SL_B:    return 11;
      default: return -1;
    endcase
  endfunction

  function automatic logic [2:0] cause_code(input logic [NCAUSE-1:0] ev);
    logic [2:0] code;
    code = 3'd0;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (ev[i]) code = 3'(i + 1);
    end
    return code;
  endfunction

endpackage

// File: rtl/vdec_syn_chk.sv
module vdec_syn_chk
  import vdec_err_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int REF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_slice_type,
  input  logic [REF_W-1:0] cfg_num_ref,
  input  logic             syn_valid,
  input  logic [2:0]       syn_kind,
  input  logic [VAL_W-1:0] syn_value,
  output logic             ev_mb,
  output logic             ev_sub,
  output logic             ev_ref,
  output logic             ev_dq
);

  int uval;
  int sval;
  int mb_lim;
  int sub_lim;

  always_comb begin
    uval    = int'(syn_value);
    sval    = int'($signed(syn_value));
    mb_lim  = mb_max(cfg_slice_type);
    sub_lim = sub_max(cfg_slice_type);
    ev_mb   = syn_valid && (syn_kind == SK_MBT) && (uval > mb_lim);
    ev_sub  = syn_valid && (((syn_kind == SK_SUB) && (uval > sub_lim)) ||
                            ((syn_kind == SK_IPM) && (uval > IPM_MAX)));
    ev_ref  = syn_valid && (syn_kind == SK_REF) && (uval >= int'(cfg_num_ref));
    ev_dq   = syn_valid && (syn_kind == SK_DQ) && ((sval < DQ_LO) || (sval > DQ_HI));
  end

  AST_QUIET_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !syn_valid |-> !(ev_mb || ev_sub || ev_ref || ev_dq)); // R11
  AST_ONE_SYNTAX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ev_mb, ev_sub, ev_ref, ev_dq}) <= 1); // R11

endmodule

// File: rtl/vdec_coef_cnt.sv
module vdec_coef_cnt #(
  parameter int MAX_COEF = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coef_mode,
  input  logic blk_start,
  input  logic coef_valid,
  output logic ev_coef
);

  localparam int CW = $clog2(MAX_COEF + 2);
  localparam logic [CW-1:0] LIM = CW'(MAX_COEF + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base;
  logic [CW-1:0] cnt_d;
  logic          inc;

  always_comb begin
    base    = blk_start ? '0 : cnt_q;
    inc     = coef_valid && (base != LIM);
    cnt_d   = inc ? base + 1'b1 : base;
    ev_coef = coef_mode && inc && (cnt_d == LIM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM); // R6
  AST_COEF_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_coef && !blk_start |=> !ev_coef); // R6

endmodule

// File: rtl/vdec_dec_timer.sv
module vdec_dec_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] cfg_timeout,
  input  logic             dec_start,
  input  logic             dec_done,
  input  logic             strm_empty,
  output logic             ev_to,
  output logic             ev_vld
);

  logic             run_q;
  logic             fired_q;
  logic [TMR_W-1:0] cnt_q;

  always_comb begin
    ev_to  = run_q && !fired_q && !dec_done && !dec_start && (cnt_q >= cfg_timeout);
    ev_vld = run_q && strm_empty && !dec_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      fired_q <= 1'b0;
      cnt_q   <= '0;
    end else if (dec_start) begin
      run_q   <= 1'b1;
      fired_q <= 1'b0;
      cnt_q   <= '0;
    end else if (run_q) begin
      if (dec_done) begin
        run_q <= 1'b0;
      end else if (ev_to) begin
        fired_q <= 1'b1;
      end else if (!fired_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_TIMEOUT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_to |=> !ev_to); // R5
  AST_IDLE_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !ev_to); // R5

endmodule

// File: rtl/vdec_err_collect.sv
module vdec_err_collect
  import vdec_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAUSE-1:0] ev,
  input  logic [NCAUSE-1:0] clr,
  output logic [NCAUSE-1:0] err_flags,
  output logic [2:0]        err_cause,
  output logic              err_irq
);

  logic [NCAUSE-1:0] fresh;

  always_comb fresh = ev & ~err_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flags <= '0;
      err_cause <= 3'd0;
      err_irq   <= 1'b0;
    end else begin
      err_flags <= (err_flags & ~clr) | ev;
      err_irq   <= |fresh;
      if (|ev) err_cause <= cause_code(ev);
    end
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_flags) & ~$past(clr) & ~err_flags) == '0); // R8
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (err_flags != '0)); // R9
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (err_cause != 3'd0)); // R10

endmodule

// File: rtl/vdec_err_mon.sv
module vdec_err_mon
  import vdec_err_pkg::*;
#(
  parameter int VAL_W    = 8,
  parameter int REF_W    = 6,
  parameter int TMR_W    = 16,
  parameter int MAX_COEF = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_slice_type,
  input  logic [REF_W-1:0] cfg_num_ref,
  input  logic [TMR_W-1:0] cfg_timeout,
  input  logic             coef_mode,
  input  logic             syn_valid,
  input  logic [2:0]       syn_kind,
  input  logic [VAL_W-1:0] syn_value,
  input  logic             blk_start,
  input  logic             coef_valid,
  input  logic             dec_start,
  input  logic             dec_done,
  input  logic             strm_empty,
  input  logic [6:0]       err_clr,
  output logic [6:0]       err_flags,
  output logic [2:0]       err_cause,
  output logic             err_irq
);

  logic ev_mb, ev_sub, ev_ref, ev_dq, ev_coef, ev_to, ev_vld;
  logic [NCAUSE-1:0] ev_all;

  vdec_syn_chk #(.VAL_W(VAL_W), .REF_W(REF_W)) u_syn (
    .clk(clk), .rst_n(rst_n),
    .cfg_slice_type(cfg_slice_type), .cfg_num_ref(cfg_num_ref),
    .syn_valid(syn_valid), .syn_kind(syn_kind), .syn_value(syn_value),
    .ev_mb(ev_mb), .ev_sub(ev_sub), .ev_ref(ev_ref), .ev_dq(ev_dq)
  );

  vdec_coef_cnt #(.MAX_COEF(MAX_COEF)) u_coef (
    .clk(clk), .rst_n(rst_n), .coef_mode(coef_mode),
    .blk_start(blk_start), .coef_valid(coef_valid), .ev_coef(ev_coef)
  );

  vdec_dec_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
    .dec_start(dec_start), .dec_done(dec_done), .strm_empty(strm_empty),
    .ev_to(ev_to), .ev_vld(ev_vld)
  );

  always_comb begin
    ev_all         = '0;
    ev_all[B_TO]   = ev_to;
    ev_all[B_VLD]  = ev_vld;
    ev_all[B_MB]   = ev_mb;
    ev_all[B_SUB]  = ev_sub;
    ev_all[B_REF]  = ev_ref;
    ev_all[B_DQ]   = ev_dq;
    ev_all[B_COEF] = ev_coef;
  end

  vdec_err_collect u_col (
    .clk(clk), .rst_n(rst_n), .ev(ev_all), .clr(err_clr),
    .err_flags(err_flags), .err_cause(err_cause), .err_irq(err_irq)
  );

endmodule

// File: tb/sim_vdec_err_mon.sv
module sim_vdec_err_mon;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_slice_type = 2'd0;
  logic [5:0]  cfg_num_ref = 6'd4;
  logic [15:0] cfg_timeout = 16'd1000;
  logic        coef_mode = 1'b1;
  logic        syn_valid = 1'b0;
  logic [2:0]  syn_kind = 3'd0;
  logic [7:0]  syn_value = 8'd0;
  logic        blk_start = 1'b0;
  logic        coef_valid = 1'b0;
  logic        dec_start = 1'b0;
  logic        dec_done = 1'b0;
  logic        strm_empty = 1'b0;
  logic [6:0]  err_clr = 7'd0;
  logic [6:0]  err_flags;
  logic [2:0]  err_cause;
  logic        err_irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string cur_req = "R8";

  always #4 clk = ~clk;

  vdec_err_mon u0 (
    .clk(clk), .rst_n(rst_n), .cfg_slice_type(cfg_slice_type),
    .cfg_num_ref(cfg_num_ref), .cfg_timeout(cfg_timeout), .coef_mode(coef_mode),
    .syn_valid(syn_valid), .syn_kind(syn_kind), .syn_value(syn_value),
    .blk_start(blk_start), .coef_valid(coef_valid), .dec_start(dec_start),
    .dec_done(dec_done), .strm_empty(strm_empty), .err_clr(err_clr),
    .err_flags(err_flags), .err_cause(err_cause), .err_irq(err_irq)
  );

  // Behavioural reference model, one update per clock edge
  int m_flags, m_cause, m_irq, m_ev, m_coefs, m_elapsed, lim, v, sv;
  bit m_open, m_fired;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0; m_cause = 0; m_irq = 0; m_coefs = 0;
      m_elapsed = 0; m_open = 0; m_fired = 0;
    end else begin
      m_ev = 0;
      v = int'(syn_value);
      sv = (v >= 128) ? v - 256 : v;
      if (syn_valid) begin
        case (syn_kind)
          3'd0: begin
            lim = (cfg_slice_type == 2'd1) ? 30 : (cfg_slice_type == 2'd2) ? 48 : 25;
            if (v > lim) m_ev |= 4;
          end
          3'd1: begin
            lim = (cfg_slice_type == 2'd1) ? 2 : (cfg_slice_type == 2'd2) ? 11 : -1;
            if (v > lim) m_ev |= 8;
          end
          3'd2: if (v > 7) m_ev |= 8;
          3'd3: if (v + 1 > int'(cfg_num_ref)) m_ev |= 16;
          3'd4: if (sv < -26 || sv > 25) m_ev |= 32;
          default: ;
        endcase
      end
      if (blk_start) m_coefs = 0;
      if (coef_valid && m_coefs < 65) begin
        m_coefs++;
        if (m_coefs == 65 && coef_mode) m_ev |= 64;
      end
      if (m_open && strm_empty && !dec_done) m_ev |= 2;
      if (dec_start) begin
        m_open = 1; m_fired = 0; m_elapsed = 0;
      end else if (m_open) begin
        if (dec_done) m_open = 0;
        else if (!m_fired) begin
          if (m_elapsed >= int'(cfg_timeout)) begin
            m_ev |= 1; m_fired = 1;
          end else m_elapsed++;
        end
      end
      m_irq = ((m_ev & ~m_flags) != 0) ? 1 : 0;
      m_flags = (m_flags & ~int'(err_clr)) | m_ev;
      if (m_ev != 0) begin
        for (int i = 6; i >= 0; i--) if (m_ev[i]) m_cause = i + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (int'(err_flags) != m_flags || int'(err_cause) != m_cause || int'(err_irq) != m_irq) begin
        fails++;
        $display("FAIL %s model: flags=%h/%h cause=%0d/%0d irq=%0d/%0d (act/exp)",
                 cur_req, err_flags, m_flags, err_cause, m_cause, err_irq, m_irq);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [7:0] val);
    syn_valid = 1'b1; syn_kind = k; syn_value = val;
    @(negedge clk);
    syn_valid = 1'b0;
  endtask

  task automatic clear_all();
    err_clr = 7'h7f;
    @(negedge clk);
    err_clr = 7'h00;
  endtask

  task automatic pulse_start();
    dec_start = 1'b1; @(negedge clk); dec_start = 1'b0;
  endtask

  task automatic pulse_done();
    dec_done = 1'b1; @(negedge clk); dec_done = 1'b0;
  endtask

  task automatic coefs(input int n);
    coef_valid = 1'b1;
    repeat (n) @(negedge clk);
    coef_valid = 1'b0;
  endtask

  task automatic new_block();
    blk_start = 1'b1; @(negedge clk); blk_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R8";
    chk("R8 reset flags", int'(err_flags), 0);
    chk("R8 reset cause", int'(err_cause), 0);
    chk("R8 reset irq", int'(err_irq), 0);

    // R1 macroblock type limits per slice
    cur_req = "R1";
    cfg_slice_type = 2'd0; send(3'd0, 8'd25);
    chk("R1 intra 25 legal", int'(err_flags), 0);
    send(3'd0, 8'd26);
    chk("R1 intra 26 flag", int'(err_flags), 4);
    chk("R9 irq on new flag", int'(err_irq), 1);
    chk("R10 cause mb", int'(err_cause), 3);
    @(negedge clk);
    chk("R9 irq one cycle", int'(err_irq), 0);
    clear_all();
    chk("R8 w1c clears", int'(err_flags), 0);
    cfg_slice_type = 2'd1; send(3'd0, 8'd30);
    chk("R1 pred 30 legal", int'(err_flags), 0);
    send(3'd0, 8'd31);
    chk("R1 pred 31 flag", int'(err_flags), 4);
    clear_all();
    cfg_slice_type = 2'd2; send(3'd0, 8'd48);
    chk("R1 bipred 48 legal", int'(err_flags), 0);
    send(3'd0, 8'd49);
    chk("R1 bipred 49 flag", int'(err_flags), 4);
    clear_all();
    cfg_slice_type = 2'd3; send(3'd0, 8'd26);
    chk("R1 code3 as intra", int'(err_flags), 4);

    // R9 sticky: repeat error gives no pulse; R8 set beats clear
    cur_req = "R9";
    send(3'd0, 8'd40);
    chk("R9 no irq when already set", int'(err_irq), 0);
    cur_req = "R8";
    err_clr = 7'h04; syn_valid = 1'b1; syn_kind = 3'd0; syn_value = 8'd99;
    @(negedge clk);
    err_clr = 7'h00; syn_valid = 1'b0;
    chk("R8 set wins over clear", int'(err_flags), 4);
    clear_all();

    // R2 sub-partition and intra mode
    cur_req = "R2";
    cfg_slice_type = 2'd1; send(3'd1, 8'd2);
    chk("R2 pred sub 2 legal", int'(err_flags), 0);
    send(3'd1, 8'd3);
    chk("R2 pred sub 3 flag", int'(err_flags), 8);
    clear_all();
    cfg_slice_type = 2'd2; send(3'd1, 8'd11);
    chk("R2 bipred sub 11 legal", int'(err_flags), 0);
    send(3'd1, 8'd12);
    chk("R2 bipred sub 12 flag", int'(err_flags), 8);
    clear_all();
    cfg_slice_type = 2'd0; send(3'd1, 8'd0);
    chk("R2 intra sub any flag", int'(err_flags), 8);
    clear_all();
    send(3'd2, 8'd7);
    chk("R2 ipm 7 legal", int'(err_flags), 0);
    send(3'd2, 8'd8);
    chk("R2 ipm 8 flag", int'(err_flags), 8);
    chk("R10 cause sub", int'(err_cause), 4);
    clear_all();

    // R3 reference index
    cur_req = "R3";
    cfg_num_ref = 6'd4; send(3'd3, 8'd3);
    chk("R3 ref 3 of 4 legal", int'(err_flags), 0);
    send(3'd3, 8'd4);
    chk("R3 ref 4 of 4 flag", int'(err_flags), 16);
    clear_all();

    // R4 quantiser delta
    cur_req = "R4";
    send(3'd4, 8'hE6);
    chk("R4 dq -26 legal", int'(err_flags), 0);
    send(3'd4, 8'd25);
    chk("R4 dq 25 legal", int'(err_flags), 0);
    send(3'd4, 8'hE5);
    chk("R4 dq -27 flag", int'(err_flags), 32);
    clear_all();
    send(3'd4, 8'd26);
    chk("R4 dq 26 flag", int'(err_flags), 32);
    chk("R10 cause dq", int'(err_cause), 6);
    clear_all();

    // R11 gating and unused kinds
    cur_req = "R11";
    syn_kind = 3'd0; syn_value = 8'd200; @(negedge clk); @(negedge clk);
    chk("R11 invalid ignored", int'(err_flags), 0);
    send(3'd5, 8'd255);
    send(3'd7, 8'd255);
    chk("R11 kinds 5..7 ignored", int'(err_flags), 0);

    // R6 coefficient overflow
    cur_req = "R6";
    coef_mode = 1'b1; new_block(); coefs(64);
    chk("R6 64 coefs legal", int'(err_flags), 0);
    coefs(1);
    chk("R6 65th coef flag", int'(err_flags), 64);
    chk("R10 cause coef", int'(err_cause), 7);
    coefs(3);
    clear_all();
    new_block(); coefs(70);
    chk("R6 one flag per block", int'(err_flags), 64);
    clear_all();
    coef_mode = 1'b0; new_block(); coefs(70);
    chk("R6 mode off ignored", int'(err_flags), 0);
    coef_mode = 1'b1;

    // R5 timeout
    cur_req = "R5";
    cfg_timeout = 16'd5;
    pulse_start(); repeat (3) @(negedge clk); pulse_done();
    chk("R5 done in time", int'(err_flags), 0);
    pulse_start();
    repeat (5) @(negedge clk);
    chk("R5 not yet at limit", int'(err_flags), 0);
    @(negedge clk);
    chk("R5 flag past limit", int'(err_flags), 1);
    chk("R10 cause timeout", int'(err_cause), 1);
    clear_all();
    repeat (10) @(negedge clk);
    chk("R5 once per decode", int'(err_flags), 0);
    pulse_start(); repeat (8) @(negedge clk);
    chk("R5 restart counts again", int'(err_flags), 1);
    pulse_done(); clear_all();

    // R7 stream empty
    cur_req = "R7";
    cfg_timeout = 16'd1000;
    strm_empty = 1'b1; @(negedge clk); strm_empty = 1'b0;
    chk("R7 idle empty ignored", int'(err_flags), 0);
    pulse_start(); @(negedge clk);
    strm_empty = 1'b1; @(negedge clk); strm_empty = 1'b0;
    chk("R7 empty in decode flag", int'(err_flags), 2);
    clear_all();

    // R10 priority in one cycle
    cur_req = "R10";
    cfg_slice_type = 2'd0;
    strm_empty = 1'b1; syn_valid = 1'b1; syn_kind = 3'd0; syn_value = 8'd60;
    @(negedge clk);
    strm_empty = 1'b0; syn_valid = 1'b0;
    chk("R10 empty beats mb flags", int'(err_flags), 6);
    chk("R10 empty beats mb cause", int'(err_cause), 2);
    pulse_done(); clear_all();
    new_block(); coefs(64);
    coef_valid = 1'b1; syn_valid = 1'b1; syn_kind = 3'd3; syn_value = 8'd9;
    @(negedge clk);
    coef_valid = 1'b0; syn_valid = 1'b0;
    chk("R10 ref beats coef flags", int'(err_flags), 80);
    chk("R10 ref beats coef cause", int'(err_cause), 5);
    @(negedge clk);
    chk("R10 cause holds", int'(err_cause), 5);
    clear_all();
    repeat (3) @(negedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule